// File: doc/BRIEF.md
# Interrupt and Overflow Aggregator

This block gathers a parameterised group of internal condition lines and turns them into one interrupt request. Every condition line has its own detection mode: rising edge, falling edge or level. Edge events are held in a sticky status register until software reads that register. A per-source enable register decides which recorded events may raise the interrupt.

A two-state machine drives the interrupt line. In ST_QUIET the line is inactive. The transition "raise" goes to ST_ACTIVE when any enabled status bit is set. The transition "drop" returns to ST_QUIET when no enabled status bit remains set. The machine stays in its state otherwise. A configuration bit sets the output style. In the push-pull style the line is driven all the time and is high while active. In the open-drain style the line is only pulled low while active and is released at all other times, so several devices can share a wired-OR line.

A separate overflow output, in open-drain style, pulls low while the ADC overflow condition or the ADC underflow condition is present. It does not depend on the enable register. Registers are accessed through a simple synchronous read and write port, and read data appears one cycle after the read strobe.

Top module: `irq_ovfl_agg`

## Requirements
- R1: After reset the status, enable and mode registers and the configuration bit all read 0 (all sources rising-edge, open-drain style). int_oe_o, int_o and ovfl_oe_o are all 0.
- R2: A source with mode 2'b00 (rising edge) sets its status bit at the clock edge that first sees its input at 1 after a 0. The bit stays set after the input returns to 0.
- R3: A source with mode 2'b01 (falling edge) sets its status bit on a 1-to-0 change of its input. A 0-to-1 change does not set it.
- R4: A source with mode 2'b10 or 2'b11 (level) has a status bit that equals the input sampled at the previous clock edge. Reading the status does not clear it.
- R5: A read of the status register at address 0x0D returns the bits as they were before the read edge and clears every edge-mode bit. An edge that arrives in the same cycle as the read leaves its bit set.
- R6: A source whose enable bit is 0 never causes the interrupt to become active, but its status bit is still recorded.
- R7: The interrupt becomes active one clock after an enabled status bit is set. It becomes inactive one clock after no enabled status bit remains set.
- R8: With configuration bit 0 = 1 (push-pull), int_oe_o is 1 and int_o equals the active state.
- R9: With configuration bit 0 = 0 (open-drain), int_o is always 0 and int_oe_o equals the active state, so the line is never driven high.
- R10: ovfl_oe_o is 1 one clock after input bit OVF_SRC (default 6) or UNF_SRC (default 7) is 1, and 0 one clock after both are 0, whatever the enable register holds.
- R11: Writes to address 0x0D have no effect. The enable register (0x0E, bit i = source i), mode registers (0x0F for sources 0-3 and 0x10 for sources 4-7, bits [2k+1:2k] for source k within the register) and configuration register (0x11, bit 0) read back the values written to them. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | NSRC | Condition lines, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data, valid the cycle after the strobe |
| int_o | output | 1 | Interrupt pad value |
| int_oe_o | output | 1 | Interrupt pad output enable |
| ovfl_oe_o | output | 1 | Overflow pad pull-low enable |

## Verification
If a status bit is wrongly set or cleared, the interrupt pad shows it one clock later, and the next status read shows it at once. A sticky bit that clears too early, or that does not clear on read, makes the interrupt pad stay on or drop at the wrong edge. The error can therefore be caught within two clocks of the stimulus. A bad edge-detector register shows up as a missed or spurious event, and also as a wrong overflow output one cycle after the overflow inputs change. A wrong configuration bit is visible on the pad pair at once, because the open-drain style must never show int_o at 1.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_LVL_X = 2'b11
    } trig_mode_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_ACTIVE = 1'b1
    } irq_state_e;

    localparam int ADDR_STATUS = 8'h0D;
    localparam int ADDR_EN     = 8'h0E;
    localparam int ADDR_MODE0  = 8'h0F;
    localparam int ADDR_CFG    = 8'h11;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cond_i,
    input  trig_mode_e mode_i,
    input  logic       rd_clr_i,
    output logic       stat_o,
    output logic       cond_q_o
);
    logic cond_q;
    logic stat_q;
    logic rise_w;
    logic fall_w;

    assign rise_w = cond_i & ~cond_q;
    assign fall_w = ~cond_i & cond_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            cond_q <= cond_i;
            unique case (mode_i)
                TRIG_RISE:              stat_q <= rise_w | (stat_q & ~rd_clr_i);
                TRIG_FALL:              stat_q <= fall_w | (stat_q & ~rd_clr_i);
                TRIG_LEVEL, TRIG_LVL_X: stat_q <= cond_i;
            endcase
        end
    end

    assign stat_o   = stat_q;
    assign cond_q_o = cond_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int AW   = 8,
    parameter int DW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NSRC-1:0]   status_i,
    output logic [DW-1:0]     rdata_o,
    output logic [NSRC-1:0]   en_o,
    output logic [2*NSRC-1:0] mode_o,
    output logic              pol_o,
    output logic              stat_clr_o
);
    localparam int NMODE = (2 * NSRC) / DW;

    logic [DW-1:0]   mode_q [NMODE];
    logic [NSRC-1:0] en_q;
    logic            pol_q;
    logic [DW-1:0]   rsel;
    logic [DW-1:0]   rdata_q;

    for (genvar k = 0; k < NMODE; k++) begin : g_mode
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q[k] <= '0;
            end else if (wr_i && addr_i == AW'(ADDR_MODE0 + k)) begin
                mode_q[k] <= wdata_i;
            end
        end
        assign mode_o[k*DW +: DW] = mode_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= 1'b0;
        end else if (wr_i) begin
            if (addr_i == AW'(ADDR_EN))  en_q  <= wdata_i[NSRC-1:0];
            if (addr_i == AW'(ADDR_CFG)) pol_q <= wdata_i[0];
        end
    end

    always_comb begin
        rsel = '0;
        if (addr_i == AW'(ADDR_STATUS)) rsel[NSRC-1:0] = status_i;
        if (addr_i == AW'(ADDR_EN))     rsel[NSRC-1:0] = en_q;
        if (addr_i == AW'(ADDR_CFG))    rsel[0]        = pol_q;
        for (int k = 0; k < NMODE; k++) begin
            if (addr_i == AW'(ADDR_MODE0 + k)) rsel = mode_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rsel;
        end
    end

    assign rdata_o    = rdata_q;
    assign en_o       = en_q;
    assign pol_o      = pol_q;
    assign stat_clr_o = rd_i && (addr_i == AW'(ADDR_STATUS));
endmodule

// File: rtl/irq_ovfl_agg.sv
module irq_ovfl_agg
    import irq_agg_pkg::*;
#(
    parameter int NSRC    = 8,
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int OVF_SRC = 6,
    parameter int UNF_SRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cond_i,
    input  logic            reg_wr_i,
    input  logic            reg_rd_i,
    input  logic [AW-1:0]   reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    output logic            int_o,
    output logic            int_oe_o,
    output logic            ovfl_oe_o
);
    logic [NSRC-1:0]   status_w;
    logic [NSRC-1:0]   cond_q_w;
    logic [NSRC-1:0]   en_w;
    logic [2*NSRC-1:0] mode_w;
    logic              pol_w;
    logic              stat_clr_w;
    logic              pending_w;
    logic              active_w;
    irq_state_e        state_q;
    irq_state_e        state_d;

    irq_regfile #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .status_i   (status_w),
        .rdata_o    (reg_rdata_o),
        .en_o       (en_w),
        .mode_o     (mode_w),
        .pol_o      (pol_w),
        .stat_clr_o (stat_clr_w)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_src_cell u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .cond_i   (cond_i[i]),
            .mode_i   (trig_mode_e'(mode_w[2*i +: 2])),
            .rd_clr_i (stat_clr_w),
            .stat_o   (status_w[i]),
            .cond_q_o (cond_q_w[i])
        );
    end

    assign pending_w = |(status_w & en_w);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_QUIET:  state_d = pending_w ? ST_ACTIVE : ST_QUIET;
            ST_ACTIVE: state_d = pending_w ? ST_ACTIVE : ST_QUIET;
        endcase
    end

    always_comb begin
        active_w = (state_q == ST_ACTIVE);
        if (pol_w) begin
            int_o    = active_w;
            int_oe_o = 1'b1;
        end else begin
            int_o    = 1'b0;
            int_oe_o = active_w;
        end
    end

    assign ovfl_oe_o = cond_q_w[OVF_SRC] | cond_q_w[UNF_SRC];
endmodule

// File: rtl/irq_ovfl_agg_chk.sv
module irq_ovfl_agg_chk #(
    parameter int NSRC    = 8,
    parameter int OVF_SRC = 6,
    parameter int UNF_SRC = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] cond_i,
    input logic [NSRC-1:0] status,
    input logic [NSRC-1:0] en,
    input logic [1:0]      mode0,
    input logic            stat_clr,
    input logic            pol,
    input logic            active,
    input logic            int_o,
    input logic            int_oe_o,
    input logic            ovfl_oe_o
);
    a_r10_ovfl_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i[OVF_SRC] || cond_i[UNF_SRC]) |=> ovfl_oe_o);

    a_r10_ovfl_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !(cond_i[OVF_SRC] || cond_i[UNF_SRC]) |=> !ovfl_oe_o);

    a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & en)) |=> active);

    a_r6_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & en)) |=> !active);

    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !mode0[1] && !stat_clr) |=> status[0]);

    a_r9_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        !pol |-> (!int_o && int_oe_o == active));

    a_r8_driven: assert property (@(posedge clk) disable iff (!rst_n)
        pol |-> (int_oe_o && int_o == active));
endmodule

bind irq_ovfl_agg irq_ovfl_agg_chk #(
    .NSRC(NSRC), .OVF_SRC(OVF_SRC), .UNF_SRC(UNF_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_i    (cond_i),
    .status    (status_w),
    .en        (en_w),
    .mode0     (mode_w[1:0]),
    .stat_clr  (stat_clr_w),
    .pol       (pol_w),
    .active    (active_w),
    .int_o     (int_o),
    .int_oe_o  (int_oe_o),
    .ovfl_oe_o (ovfl_oe_o)
);

// File: tb/test_irq_ovfl_agg.sv
module test_irq_ovfl_agg;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cond = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       int_o;
    logic       int_oe;
    logic       ovfl_oe;

    int checks = 0;
    int errors = 0;

    // table entry: {cond, expected int, expected ovfl}
    localparam logic [9:0] VEC [8] = '{
        {8'h00, 1'b0, 1'b0},
        {8'h01, 1'b1, 1'b0},
        {8'h02, 1'b0, 1'b0},
        {8'h04, 1'b1, 1'b0},
        {8'h40, 1'b0, 1'b1},
        {8'h80, 1'b0, 1'b1},
        {8'h05, 1'b1, 1'b0},
        {8'h00, 1'b0, 1'b0}
    };

    always #(PERIOD/2) clk = ~clk;

    irq_ovfl_agg i_irq_ovfl_agg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_i      (cond),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .int_o       (int_o),
        .int_oe_o    (int_oe),
        .ovfl_oe_o   (ovfl_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        step(2);
        chk("R1 int_oe", int_oe, 0);
        chk("R1 int_o", int_o, 0);
        chk("R1 ovfl", ovfl_oe, 0);
        rst_n = 1'b1;
        step(1);
        rreg(8'h0D, v); chk("R1 status", v, 0);
        rreg(8'h0E, v); chk("R1 enable", v, 0);
        rreg(8'h0F, v); chk("R1 mode lo", v, 0);
        rreg(8'h11, v); chk("R1 cfg", v, 0);

        // table: all level mode, enable 0x05, push-pull
        wreg(8'h0F, 8'hAA);
        wreg(8'h10, 8'hAA);
        wreg(8'h0E, 8'h05);
        wreg(8'h11, 8'h01);
        for (int i = 0; i < 8; i++) begin
            cond = VEC[i][9:2];
            step(2);
            chk("R4 R6 R8 table int_o", int_o, VEC[i][1]);
            chk("R8 table int_oe", int_oe, 1);
            chk("R10 table ovfl", ovfl_oe, VEC[i][0]);
        end

        // R11 readback and unmapped address
        rreg(8'h0E, v); chk("R11 enable readback", v, 8'h05);
        rreg(8'h10, v); chk("R11 mode hi readback", v, 8'hAA);
        rreg(8'h11, v); chk("R11 cfg readback", v, 8'h01);
        rreg(8'h20, v); chk("R11 unmapped", v, 0);

        // R4: level bit survives reads
        cond = 8'h04; step(1);
        rreg(8'h0D, v); chk("R4 level read1", v, 8'h04);
        rreg(8'h0D, v); chk("R4 level read2", v, 8'h04);
        cond = 8'h00; step(1);
        rreg(8'h0D, v); chk("R4 level follows", v, 8'h00);

        // R6: masked source recorded but no interrupt
        cond = 8'h02; step(2);
        chk("R6 masked int", int_o, 0);
        rreg(8'h0D, v); chk("R6 masked recorded", v, 8'h02);
        cond = 8'h00; step(1);

        // switch to edge modes: src0 rising, src1 falling
        wreg(8'h0F, 8'h04);
        wreg(8'h10, 8'h00);
        wreg(8'h0E, 8'h03);
        rreg(8'h0D, v);
        step(1);

        // R2 / R7: rising and sticky
        cond = 8'h01; step(1);
        chk("R7 not yet active", int_o, 0);
        step(1);
        chk("R2 R7 rise active", int_o, 1);
        cond = 8'h00; step(2);
        chk("R2 sticky after fall", int_o, 1);
        rreg(8'h0D, v); chk("R5 read returns bit", v, 8'h01);
        chk("R7 still active at clear edge", int_o, 1);
        step(1);
        chk("R7 drop after clear", int_o, 0);
        rreg(8'h0D, v); chk("R5 cleared", v, 8'h00);

        // R5: edge in same cycle as read wins
        cond = 8'h01;
        rreg(8'h0D, v); chk("R5 read before edge", v, 8'h00);
        rreg(8'h0D, v); chk("R5 edge kept", v, 8'h01);

        // R3: falling mode on source 1
        cond = 8'h03; step(1);
        rreg(8'h0D, v); chk("R3 no set on rise", v, 8'h00);
        cond = 8'h01; step(1);
        rreg(8'h0D, v); chk("R3 set on fall", v, 8'h02);

        // R11: status write ignored
        wreg(8'h0D, 8'hFF);
        rreg(8'h0D, v); chk("R11 status write ignored", v, 8'h00);

        // R9: open-drain style
        wreg(8'h11, 8'h00);
        cond = 8'h00; step(1);
        cond = 8'h01; step(2);
        chk("R9 od int_o", int_o, 0);
        chk("R9 od int_oe", int_oe, 1);
        rreg(8'h0D, v); step(1);
        chk("R9 od released", int_oe, 0);
        chk("R9 od low", int_o, 0);

        // R10: overflow independent of enables
        wreg(8'h0E, 8'h00);
        cond = 8'h80; step(1);
        chk("R10 underflow", ovfl_oe, 1);
        cond = 8'h00; step(1);
        chk("R10 release", ovfl_oe, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule